// File: doc/BRIEF.md
# Bitstream Header Ratio Selector

This block sits beside a configuration data path and watches the words of a bitstream as they go by. It does not alter or stall the stream. From two fixed word positions near the start of the image it picks up whether the image is encrypted and whether it is compressed. When the later of the two words arrives, it combines these two indicators with the selected bus width and produces the 2-bit code that sets the configuration clock-to-data ratio.

A new stream is marked by a start flag on its first word. The result and the two captured indicators stay on the outputs until the next start. If the stream ends before the classifying word arrives, an error flag is raised in place of a result. Writing the code into any control register is left to the logic around the block.

Top module: `hdr_ratio_sel`

## Requirements
- R1: Encryption is detected when bits [3:2] of the word with index 69 hold a nonzero value. Every other bit of that word has no effect on detection.
- R2: Compression is detected when bit 1 of the word with index 229 is 0. Every other bit of that word has no effect on detection.
- R3: The ratio code means x1 when 0, x2 when 1, x4 when 2 and x8 when 3. With neither encryption nor compression the code is 0 at either width.
- R4: When `wide_sel` is 0 (16-bit bus), the code is 2 for a compressed image and 1 for an image that is encrypted but not compressed.
- R5: When `wide_sel` is 1 (32-bit bus), the code is one more than the 16-bit code in every case except the one with neither indicator set. `wide_sel` is sampled in the cycle word 229 is accepted.
- R6: `hdr_done` is high for exactly one cycle, in the cycle after word 229 is accepted. In that same cycle `ratio_code`, `enc_flag` and `cmp_flag` take their new values. They hold those values until the next start word. Before the first result they read 0.
- R7: If a word with `word_last` high is accepted at an index below 229, `hdr_err` goes high in the following cycle and stays high until the next start word. No `hdr_done` pulse occurs for that stream.
- R8: A word is accepted only in a cycle where `word_valid` is high. A word with `word_first` high has index 0, and each later accepted word takes the next index. Cycles without `word_valid` do not advance the index.
- R9: A start word that arrives before index 229 is reached discards everything captured so far. The start word also clears `hdr_err` and the previous result in the following cycle.
- R10: Words accepted after word 229 are ignored, and so are words seen after reset before any start word. This includes words that carry `word_last`.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | A stream word is present this cycle |
| word_first | input | 1 | This word opens a new stream (index 0) |
| word_last | input | 1 | This word closes the stream |
| word_data | input | 32 | Stream word |
| wide_sel | input | 1 | Bus width: 1 = 32-bit, 0 = 16-bit |
| ratio_code | output | 2 | Clock-to-data ratio code |
| enc_flag | output | 1 | Captured encryption indicator |
| cmp_flag | output | 1 | Captured compression indicator |
| hdr_done | output | 1 | One-cycle pulse when the classification completes |
| hdr_err | output | 1 | Stream ended before the classifying word |

## Verification
The hardest case to reach is the index arithmetic under an irregular stream. The result must come from exactly the 230th accepted word, even when idle cycles are mixed in and a restart cancels a half-captured header that had already seen an encrypted word 69. The stimulus inserts idle cycles at a fixed stride, including next to words 69 and 229. It checks that nothing completes after word 228. It then restarts a stream partway through so that a stale encryption indicator would show up in the code. Separate streams place noise bits around the tested fields, so that a wrong bit position changes the code.

// File: rtl/hdr_ratio_sel.sv
module hdr_ratio_sel #(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2,
  parameter int CMP_IDX = 229,
  parameter int CMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic              word_first,
  input  logic              word_last,
  input  logic [DATA_W-1:0] word_data,
  input  logic              wide_sel,
  output logic [1:0]        ratio_code,
  output logic              enc_flag,
  output logic              cmp_flag,
  output logic              hdr_done,
  output logic              hdr_err
);

  localparam int CNT_W = $clog2(CMP_IDX + 1);

  logic             active;
  logic [CNT_W-1:0] idx;
  logic             enc_seen;
  logic             done_q, err_q, enc_q, cmp_q;
  logic [1:0]       ratio_q;

  logic             take, at_enc, at_cmp;
  logic [CNT_W-1:0] cur_idx;
  logic             enc_now, cmp_now;

  function automatic logic [1:0] pick_ratio(input logic wide, input logic enc, input logic cmp);
    logic [1:0] base;
    if (!enc && !cmp) return 2'd0;
    base = cmp ? 2'd2 : 2'd1;
    return base + {1'b0, wide};
  endfunction

  assign take    = word_valid && (word_first || active);
  assign cur_idx = word_first ? '0 : idx;
  assign at_enc  = take && (cur_idx == CNT_W'(ENC_IDX));
  assign at_cmp  = take && (cur_idx == CNT_W'(CMP_IDX));
  assign enc_now = at_enc ? |word_data[ENC_LSB +: ENC_W] : (!word_first && enc_seen);
  assign cmp_now = ~word_data[CMP_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      idx      <= '0;
      enc_seen <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      enc_q    <= 1'b0;
      cmp_q    <= 1'b0;
      ratio_q  <= 2'd0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        if (word_first) begin
          active  <= 1'b1;
          err_q   <= 1'b0;
          enc_q   <= 1'b0;
          cmp_q   <= 1'b0;
          ratio_q <= 2'd0;
        end
        enc_seen <= enc_now;
        if (at_cmp) begin
          active  <= 1'b0;
          done_q  <= 1'b1;
          enc_q   <= enc_now;
          cmp_q   <= cmp_now;
          ratio_q <= pick_ratio(wide_sel, enc_now, cmp_now);
        end else if (word_last) begin
          active <= 1'b0;
          err_q  <= 1'b1;
        end else begin
          idx <= cur_idx + 1'b1;
        end
      end
    end
  end

  assign ratio_code = ratio_q;
  assign enc_flag   = enc_q;
  assign cmp_flag   = cmp_q;
  assign hdr_done   = done_q;
  assign hdr_err    = err_q;

endmodule

module hdr_ratio_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       word_valid,
  input logic       word_first,
  input logic       wide_sel,
  input logic [1:0] ratio_code,
  input logic       enc_flag,
  input logic       cmp_flag,
  input logic       hdr_done,
  input logic       hdr_err
);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |=> !hdr_done);

  a_r7_err_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> !hdr_done);

  a_r3_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && !enc_flag && !cmp_flag) |-> ratio_code == 2'd0);

  a_r4_narrow_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && cmp_flag && !$past(wide_sel)) |-> ratio_code == 2'd2);

  a_r5_wide_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && cmp_flag && $past(wide_sel)) |-> ratio_code == 2'd3);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(word_valid && word_first) && !hdr_done) |-> $stable(ratio_code));

endmodule

bind hdr_ratio_sel hdr_ratio_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_first(word_first),
  .wide_sel(wide_sel), .ratio_code(ratio_code), .enc_flag(enc_flag),
  .cmp_flag(cmp_flag), .hdr_done(hdr_done), .hdr_err(hdr_err)
);

// File: tb/test_hdr_ratio_sel.sv
`timescale 1ns/1ps
module test_hdr_ratio_sel;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        word_valid = 0, word_first = 0, word_last = 0, wide_sel = 0;
  logic [31:0] word_data = '0;
  logic [1:0]  ratio_code;
  logic        enc_flag, cmp_flag, hdr_done, hdr_err;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  hdr_ratio_sel i_hdr_ratio_sel (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_first(word_first),
    .word_last(word_last), .word_data(word_data), .wide_sel(wide_sel),
    .ratio_code(ratio_code), .enc_flag(enc_flag), .cmp_flag(cmp_flag),
    .hdr_done(hdr_done), .hdr_err(hdr_err)
  );

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int exp_ratio(input bit wide, input bit enc, input bit cmp);
    case ({wide, enc, cmp})
      3'b000, 3'b100: return 0;
      3'b010:         return 1;
      3'b001, 3'b011: return 2;
      3'b110:         return 2;
      default:        return 3;
    endcase
  endfunction

  task automatic put(input logic [31:0] d, input bit f, input bit l);
    @(negedge clk);
    word_valid = 1; word_data = d; word_first = f; word_last = l;
    @(posedge clk); #1;
    word_valid = 0; word_first = 0; word_last = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic logic [31:0] word_at(input int i, input logic [1:0] eb, input bit cmp_bit1);
    if (i == 69)  return 32'h0000_0013 | {28'd0, eb, 2'b00};
    if (i == 229) return cmp_bit1 ? 32'h0000_0002 : 32'hFFFF_FFFD;
    return {i[15:0], 16'h5A0C};
  endfunction

  task automatic stream(input logic [1:0] eb, input bit cmp_bit1, input int n,
                        input int gap_every, input bit end_last);
    for (int i = 0; i < n; i++) begin
      if (gap_every > 0 && (i % gap_every) == 0 && i != 0) idle(2);
      put(word_at(i, eb, cmp_bit1), i == 0, end_last && i == n - 1);
    end
  endtask

  task automatic t_reset;
    chk(ratio_code, 0, "R11 ratio after reset");
    chk(enc_flag, 0, "R11 enc after reset");
    chk(cmp_flag, 0, "R11 cmp after reset");
    chk(hdr_done, 0, "R11 done after reset");
    chk(hdr_err, 0, "R11 err after reset");
  endtask

  task automatic t_combo(input bit wide, input logic [1:0] eb, input bit cmp_bit1);
    bit enc = (eb != 0);
    bit cmp = !cmp_bit1;
    wide_sel = wide;
    stream(eb, cmp_bit1, 229, 0, 0);
    chk(hdr_done, 0, "R8 no done after word 228");
    put(word_at(229, eb, cmp_bit1), 0, 1);
    chk(hdr_done, 1, "R6 done pulse");
    chk(enc_flag, enc, "R1 enc flag");
    chk(cmp_flag, cmp, "R2 cmp flag");
    chk(ratio_code, exp_ratio(wide, enc, cmp), wide ? "R5 wide ratio" : "R4 narrow ratio");
    chk(hdr_err, 0, "R7 no err on full stream");
    wide_sel = !wide;
    idle(2);
    chk(hdr_done, 0, "R6 done is one cycle");
    chk(ratio_code, exp_ratio(wide, enc, cmp), "R6 ratio held");
    chk(enc_flag, enc, "R6 enc held");
  endtask

  task automatic t_short;
    wide_sel = 1;
    stream(2'b11, 0, 101, 0, 1);
    chk(hdr_err, 1, "R7 err on short stream");
    chk(hdr_done, 0, "R7 no done on short stream");
    chk(ratio_code, 0, "R7 ratio cleared");
    idle(5);
    chk(hdr_err, 1, "R7 err held");
    put(word_at(0, 0, 1), 1, 0);
    chk(hdr_err, 0, "R9 err cleared by start");
    stream(2'b00, 1, 230, 0, 1);
    chk(hdr_err, 0, "R7 err stays low on full stream");
    chk(ratio_code, 0, "R3 all off wide");
  endtask

  task automatic t_restart;
    wide_sel = 0;
    stream(2'b10, 1, 150, 0, 0);
    stream(2'b00, 1, 230, 0, 0);
    chk(hdr_done, 1, "R9 restart completes");
    chk(enc_flag, 0, "R9 stale enc discarded");
    chk(ratio_code, 0, "R9 ratio from fresh stream");
  endtask

  task automatic t_gaps;
    wide_sel = 1;
    stream(2'b01, 0, 229, 23, 0);
    chk(hdr_done, 0, "R8 gaps not counted");
    idle(3);
    put(word_at(229, 2'b01, 0), 0, 0);
    chk(hdr_done, 1, "R8 done on 230th word");
    chk(ratio_code, 3, "R5 wide enc+cmp");
  endtask

  task automatic t_after;
    bit seen = 0;
    for (int i = 0; i < 20; i++) begin
      put(32'h0000_0000, 0, i == 19);
      if (hdr_done || hdr_err) seen = 1;
    end
    chk(seen, 0, "R10 words after completion ignored");
    chk(ratio_code, 3, "R10 ratio unchanged after extra words");
    chk(cmp_flag, 1, "R10 cmp unchanged after extra words");
  endtask

  task automatic t_pre_start;
    bit seen = 0;
    rst_n = 0; idle(2); rst_n = 1;
    t_reset();
    for (int i = 0; i < 240; i++) begin
      put(word_at(i, 2'b11, 0), 0, i == 239);
      if (hdr_done || hdr_err) seen = 1;
    end
    chk(seen, 0, "R10 words before start ignored");
    chk(ratio_code, 0, "R10 ratio stays zero before start");
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset();
    for (int w = 0; w < 2; w++) begin
      t_combo(w[0], 2'b00, 1);
      t_combo(w[0], 2'b00, 0);
      t_combo(w[0], 2'b01, 1);
      t_combo(w[0], 2'b10, 0);
      t_combo(w[0], 2'b11, 1);
      t_combo(w[0], 2'b11, 0);
    end
    t_short();
    t_restart();
    t_gaps();
    t_after();
    t_pre_start();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule